// File: doc/BRIEF.md
# Dirty-Page Display Refresh Scanner

This controller decides which parts of a frame have to be redrawn. It walks a per-page dirty bitmap held in external storage, one group index per clock. Each entry stands for a band of four display lines. Consecutive dirty bands are merged into a single full-width update rectangle. Each rectangle is handed downstream as a (first line, line count) record over a valid/ready handshake. While it walks, the scanner remembers the lowest and the highest dirty group. After the walk it issues one clear request for that inclusive span, so the same changes are not drawn again on the next frame.

Two depths are supported, chosen when a scan starts. In the shallow depth only the 8-bit plane's page decides whether a band is dirty. In the deep depth a band also counts as dirty when any of the four matching pages in the direct-colour plane or in the control plane is marked. The clear request then also reports the four-times-wider page span in those planes. A separate invalidate command asks the storage to mark every page, which forces a complete redraw on the next scan. The storage is outside this block and is reached through a read port (group index out, dirty bits in, same cycle) and a clear/set port.

Top module: `dirty_scan`

## Requirements
- R1: After reset the block is idle and rect_valid, clr_valid, done and set_all are all low.
- R2: Group index g stands for display lines 4g to 4g+3. The scan reads groups 0 to GROUPS-1 in ascending order on grp_idx, where GROUPS = ceil(ACTIVE_H/4).
- R3: Each maximal run of consecutive dirty groups that ends at a clean group yields exactly one record, with rect_y = 4 × first group and rect_h = 4 × run length. Records leave in ascending rect_y order.
- R4: A run still open at the last group is emitted as a final record with rect_h = 4 × GROUPS − rect_y.
- R5: With deep_mode high at start, a group is dirty when dirty8 is set, or any bit of dirty_dir[3:0] or dirty_ctl[3:0] is set. Bit i of each of these vectors stands for page 4g+i of its plane. With deep_mode low, dirty_dir and dirty_ctl have no effect.
- R6: If at least one group was dirty, exactly one single-cycle clr_valid follows the last record. It carries clr_lo and clr_hi equal to the lowest and highest dirty group. It also carries clr_wide_lo = 4·clr_lo and clr_wide_hi = 4·clr_hi+3, and clr_deep equal to the depth of the scan.
- R7: If no group was dirty, the scan emits no record and no clr_valid.
- R8: While rect_valid is high and rect_ready low, the record stays unchanged and the scan does not advance.
- R9: start is accepted only when idle. A start pulse during a scan does not begin a second scan.
- R10: An invalidate pulse produces one single-cycle set_all while idle. If it arrives during a scan, set_all is held back until the scan has ended. A start is ignored while an invalidate is pending or set_all is high.
- R11: Every scan ends with a single-cycle done pulse. rect_w always equals ACTIVE_W, and every rectangle starts at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (idle only) |
| deep_mode | input | 1 | Depth for the scan: 1 = also use direct and control planes |
| invalidate | input | 1 | Request that every page be marked dirty |
| grp_idx | output | GW | Group currently read from the bitmap |
| dirty8 | input | 1 | 8-bit plane dirty bit of group grp_idx |
| dirty_dir | input | 4 | Direct-plane dirty bits of pages 4·grp_idx+i |
| dirty_ctl | input | 4 | Control-plane dirty bits of pages 4·grp_idx+i |
| rect_valid | output | 1 | Update record available |
| rect_ready | input | 1 | Downstream accepts the record |
| rect_y | output | LW | First line of the rectangle |
| rect_h | output | LW | Number of lines in the rectangle |
| rect_w | output | WW | Rectangle width (always ACTIVE_W) |
| clr_valid | output | 1 | Single-cycle clear request |
| clr_lo | output | GW | Lowest dirty group |
| clr_hi | output | GW | Highest dirty group |
| clr_wide_lo | output | GW+2 | First page to clear in the direct/control planes |
| clr_wide_hi | output | GW+2 | Last page to clear in the direct/control planes |
| clr_deep | output | 1 | Clear also applies to the direct/control planes |
| set_all | output | 1 | Single-cycle request to mark every page dirty |
| done | output | 1 | Single-cycle end-of-scan pulse |

## Verification
The assertions check these properties on every cycle: a stalled record stays unchanged, every rectangle is four-line aligned and non-empty, a clear span is ordered, done and set_all last one cycle, set_all never overlaps an emission or a clear, and the read index stays in range. Only the bench scenarios can show that the record sequence matches the bitmap. This covers run merging, the final open run, deep versus shallow combination, and the min/max clear span. They also show that empty bitmaps give nothing but done, that a start during a scan is dropped, and that an invalidate during a scan is held back and then marks everything.

// File: rtl/dirty_scan.sv
module dirty_scan #(
  parameter int ACTIVE_W = 1024,
  parameter int ACTIVE_H = 768,
  localparam int GROUPS = (ACTIVE_H + 3) / 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int LW = GW + 3,
  localparam int WW = $clog2(ACTIVE_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          deep_mode,
  input  logic          invalidate,
  output logic [GW-1:0] grp_idx,
  input  logic          dirty8,
  input  logic [3:0]    dirty_dir,
  input  logic [3:0]    dirty_ctl,
  output logic          rect_valid,
  input  logic          rect_ready,
  output logic [LW-1:0] rect_y,
  output logic [LW-1:0] rect_h,
  output logic [WW-1:0] rect_w,
  output logic          clr_valid,
  output logic [GW-1:0] clr_lo,
  output logic [GW-1:0] clr_hi,
  output logic [GW+1:0] clr_wide_lo,
  output logic [GW+1:0] clr_wide_hi,
  output logic          clr_deep,
  output logic          set_all,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_EMIT, S_CLR, S_DONE} state_t;

  state_t        state;
  logic [GW-1:0] grp, min_g, max_g;
  logic [LW-1:0] run_start;
  logic          run_open, any_hit, at_end, deep_r, inval_pend;

  logic          hit, last, close;
  logic [LW-1:0] line, run_y, end_line;

  assign line     = {1'b0, grp, 2'b00};
  assign hit      = dirty8 | (deep_r & ((|dirty_dir) | (|dirty_ctl)));
  assign last     = grp == GW'(GROUPS - 1);
  assign run_y    = run_open ? run_start : line;
  assign end_line = hit ? line + LW'(4) : line;
  assign close    = (run_open & ~hit) | (hit & last);

  assign grp_idx     = grp;
  assign rect_valid  = state == S_EMIT;
  assign clr_valid   = state == S_CLR;
  assign done        = state == S_DONE;
  assign rect_w      = WW'(ACTIVE_W);
  assign clr_lo      = min_g;
  assign clr_hi      = max_g;
  assign clr_wide_lo = {min_g, 2'b00};
  assign clr_wide_hi = {max_g, 2'b11};
  assign clr_deep    = deep_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      grp        <= '0;
      min_g      <= '0;
      max_g      <= '0;
      run_start  <= '0;
      run_open   <= 1'b0;
      any_hit    <= 1'b0;
      at_end     <= 1'b0;
      deep_r     <= 1'b0;
      inval_pend <= 1'b0;
      set_all    <= 1'b0;
      rect_y     <= '0;
      rect_h     <= '0;
    end else begin
      set_all <= 1'b0;
      if (state != S_IDLE && invalidate) inval_pend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (invalidate || inval_pend) begin
            set_all    <= 1'b1;
            inval_pend <= 1'b0;
          end else if (start && !set_all) begin
            state    <= S_SCAN;
            grp      <= '0;
            run_open <= 1'b0;
            any_hit  <= 1'b0;
            at_end   <= 1'b0;
            deep_r   <= deep_mode;
          end
        end
        S_SCAN: begin
          if (hit) begin
            any_hit <= 1'b1;
            if (!any_hit) min_g <= grp;
            max_g     <= grp;
            run_start <= run_y;
          end
          if (close) begin
            rect_y   <= run_y;
            rect_h   <= end_line - run_y;
            run_open <= 1'b0;
            state    <= S_EMIT;
          end else begin
            run_open <= hit;
          end
          if (last) begin
            at_end <= 1'b1;
            if (!close) state <= (any_hit || hit) ? S_CLR : S_DONE;
          end else begin
            grp <= grp + GW'(1);
          end
        end
        S_EMIT: begin
          if (rect_ready) state <= at_end ? (any_hit ? S_CLR : S_DONE) : S_SCAN;
        end
        S_CLR:  state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dirty_scan_chk.sv
module dirty_scan_chk #(
  parameter int GW = 4,
  parameter int LW = 7,
  parameter int NG = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rect_valid,
  input logic          rect_ready,
  input logic [LW-1:0] rect_y,
  input logic [LW-1:0] rect_h,
  input logic          clr_valid,
  input logic [GW-1:0] clr_lo,
  input logic [GW-1:0] clr_hi,
  input logic          set_all,
  input logic          done,
  input logic [GW-1:0] grp_idx
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h));

  p_rect_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> rect_h != '0 && rect_y[1:0] == 2'b00 && rect_h[1:0] == 2'b00);

  p_clr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_lo <= clr_hi);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_setall_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_all |=> !set_all);

  p_setall_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_all |-> !rect_valid && !clr_valid && !done);

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(grp_idx) < NG);
endmodule

bind dirty_scan dirty_scan_chk #(.GW(GW), .LW(LW), .NG(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rect_valid(rect_valid), .rect_ready(rect_ready),
  .rect_y(rect_y), .rect_h(rect_h), .clr_valid(clr_valid), .clr_lo(clr_lo),
  .clr_hi(clr_hi), .set_all(set_all), .done(done), .grp_idx(grp_idx)
);

// File: tb/tb_dirty_scan.sv
module tb_dirty_scan;
  localparam int AW = 1024;
  localparam int AH = 60;
  localparam int NG = (AH + 3) / 4;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;
  localparam int LW = GW + 3;
  localparam int WW = $clog2(AW + 1);
  localparam int FULLG = 192;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, deep_mode = 1'b0, invalidate = 1'b0;
  logic [GW-1:0] grp_idx;
  logic dirty8;
  logic [3:0] dirty_dir, dirty_ctl;
  logic rect_valid, rect_ready = 1'b0;
  logic [LW-1:0] rect_y, rect_h;
  logic [WW-1:0] rect_w;
  logic clr_valid, clr_deep, set_all, done;
  logic [GW-1:0] clr_lo, clr_hi;
  logic [GW+1:0] clr_wide_lo, clr_wide_hi;

  bit m8 [FULLG];
  bit mdir [4*FULLG];
  bit mctl [4*FULLG];

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dirty_scan #(.ACTIVE_W(AW), .ACTIVE_H(AH)) dut (.*);

  always_comb begin
    dirty8 = m8[grp_idx];
    for (int i = 0; i < 4; i++) begin
      dirty_dir[i] = mdir[4*grp_idx + i];
      dirty_ctl[i] = mctl[4*grp_idx + i];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual=%0d cycles, expected<150000)", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit grp_dirty(input int g, input bit deep);
    bit h = m8[g];
    if (deep) for (int i = 0; i < 4; i++) h = h | mdir[4*g+i] | mctl[4*g+i];
    return h;
  endfunction

  task automatic clear_map();
    for (int i = 0; i < FULLG; i++) m8[i] = 0;
    for (int i = 0; i < 4*FULLG; i++) begin mdir[i] = 0; mctl[i] = 0; end
  endtask

  task automatic fill_random(input int pct);
    clear_map();
    for (int g = 0; g < NG; g++) begin
      m8[g] = ($urandom % 100) < pct;
      for (int i = 0; i < 4; i++) begin
        mdir[4*g+i] = ($urandom % 100) < pct / 3;
        mctl[4*g+i] = ($urandom % 100) < pct / 3;
      end
    end
  endtask

  task automatic run_scan(input bit deep, input bit poke_start, input bit poke_inval);
    int ey[NG], eh[NG];
    int n = 0, lo = -1, hi = -1, k = 0, nclr = 0, nset = 0, ndone = 0, t = 0;
    int rs = -1;
    for (int g = 0; g < NG; g++) begin
      if (grp_dirty(g, deep)) begin
        if (lo < 0) lo = g;
        hi = g;
        if (rs < 0) rs = 4*g;
      end else if (rs >= 0) begin
        ey[n] = rs; eh[n] = 4*g - rs; n++; rs = -1;
      end
    end
    if (rs >= 0) begin ey[n] = rs; eh[n] = 4*NG - rs; n++; end

    @(negedge clk);
    deep_mode = deep; start = 1'b1;
    @(negedge clk);
    start = 1'b0; deep_mode = ~deep;
    while (ndone == 0 && t < 5000) begin
      rect_ready = ($urandom % 10) < 7;
      start = poke_start && (t == 3);
      invalidate = poke_inval && (t == 2);
      #1;
      if (rect_valid && rect_ready) begin
        chk(k < n, "R3 extra record", k, n);
        if (k < n) begin
          chk(int'(rect_y) == ey[k], "R3 rect_y", rect_y, ey[k]);
          chk(int'(rect_h) == eh[k], (k == n-1 && ey[k]+eh[k] == 4*NG) ? "R4 rect_h" : "R3 rect_h",
              rect_h, eh[k]);
          chk(int'(rect_w) == AW, "R11 rect_w", rect_w, AW);
        end
        k++;
      end
      if (clr_valid) begin
        nclr++;
        chk(k == n, "R6 clear after last record", k, n);
        chk(int'(clr_lo) == lo, "R6 clr_lo", clr_lo, lo);
        chk(int'(clr_hi) == hi, "R6 clr_hi", clr_hi, hi);
        chk(clr_deep == deep, "R6 clr_deep", clr_deep, deep);
        chk(int'(clr_wide_lo) == 4*lo && int'(clr_wide_hi) == 4*hi+3, "R6 wide span",
            clr_wide_hi, 4*hi+3);
        for (int g = int'(clr_lo); g <= int'(clr_hi); g++) m8[g] = 0;
        if (clr_deep)
          for (int p = int'(clr_wide_lo); p <= int'(clr_wide_hi); p++) begin
            mdir[p] = 0; mctl[p] = 0;
          end
      end
      if (set_all) nset++;
      if (done) ndone++;
      @(negedge clk);
      t++;
    end
    invalidate = 1'b0; start = 1'b0;
    chk(ndone == 1, "R11 done seen", ndone, 1);
    chk(k == n, "R3 record count", k, n);
    chk(nclr == (n > 0 ? 1 : 0), n > 0 ? "R6 clear count" : "R7 no clear", nclr, n > 0);
    chk(nset == 0, "R10 set_all held during scan", nset, 0);
    for (int w = 0; w < 6; w++) begin
      #1;
      if (done) ndone++;
      if (rect_valid) k++;
      if (set_all) begin
        nset++;
        for (int i = 0; i < FULLG; i++) m8[i] = 1;
        for (int i = 0; i < 4*FULLG; i++) begin mdir[i] = 1; mctl[i] = 1; end
      end
      @(negedge clk);
    end
    if (poke_start) chk(ndone == 1 && k == n, "R9 no second scan", ndone, 1);
    chk(nset == (poke_inval ? 1 : 0), "R10 deferred set_all", nset, poke_inval);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_map();
    repeat (3) @(negedge clk);
    chk(!rect_valid && !clr_valid && !done && !set_all, "R1 reset outputs",
        {rect_valid, clr_valid, done, set_all}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rect_valid && !clr_valid && !done && !set_all, "R1 idle after reset",
        {rect_valid, clr_valid, done, set_all}, 0);

    clear_map();
    run_scan(1'b0, 1'b0, 1'b0);                       // R7 empty
    for (int g = 0; g < NG; g++) begin mdir[4*g] = 1; mctl[4*g+3] = 1; end
    run_scan(1'b0, 1'b0, 1'b0);                       // R5 shallow ignores deep planes
    run_scan(1'b1, 1'b0, 1'b0);                       // R5 deep picks them up, R4 full run
    clear_map(); m8[NG-1] = 1;
    run_scan(1'b0, 1'b0, 1'b0);                       // R4 single last group
    clear_map(); m8[0] = 1; m8[2] = 1; m8[3] = 1; mdir[4*7+2] = 1;
    run_scan(1'b1, 1'b1, 1'b0);                       // R3 runs, R9 start while busy
    clear_map(); m8[5] = 1;
    run_scan(1'b0, 1'b0, 1'b1);                       // R10 invalidate during scan
    run_scan(1'b1, 1'b0, 1'b0);                       // R2 whole area after set_all
    run_scan(1'b1, 1'b0, 1'b0);                       // R6 cleared, now empty

    @(negedge clk); invalidate = 1'b1; start = 1'b1; deep_mode = 1'b0;
    @(negedge clk); invalidate = 1'b0;
    #1; chk(set_all == 1'b1, "R10 set_all while idle", set_all, 1);
    @(negedge clk); start = 1'b0;
    repeat (4) begin #1; chk(!rect_valid && !done, "R10 start ignored during set_all", done, 0);
      @(negedge clk); end

    for (int r = 0; r < 25; r++) begin
      fill_random(10 + ($urandom % 60));
      run_scan(1'($urandom % 2), 1'b0, 1'b0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule